// File: doc/BRIEF.md
# Software Interrupt Priority Scheduler

The block holds a bank of software-raised interrupt sources for one processor. Any bus master can raise a source or withdraw it through one control word, and can read back which sources are still waiting. Each source carries a programmable priority. The block asks the processor for service whenever the best waiting priority is strictly above the processor's current priority, and it names the source that should run.

When the processor acknowledges, the block saves the current priority on a last-in first-out stack and raises the current priority to that of the serviced source. An end-of-interrupt write takes the saved priority back off the stack. Each acknowledge strictly raises the current priority, so a stack with one entry per priority level cannot overflow. For the same reason, software may not move the current priority below the priority of the running handler. Such a write is refused and reported on an error pulse.

A source stays waiting until software withdraws it. A requester can poll the waiting bit to learn whether earlier work has finished before it raises the source again. When a high-priority handler raises a lower source and then ends, the lower source is dispatched by priority after the end-of-interrupt write.

Top module: `swi_sched`

## Requirements
- R1: After reset no source is waiting, every priority field and the current priority are 0, the stack depth is 0, and irqReq and prioErr are low.
- R2: A write to address 0 sets source i waiting for each 1 in data bit i (i = 0..7). A read of address 0 returns the waiting bits in data bits 15:8 and zeros in bits 7:0.
- R3: A 1 in data bit 8+i of a write to address 0 withdraws source i. Zero bits leave their sources unchanged. When the same write sets and withdraws a source, the withdraw wins.
- R4: irqReq is high exactly when the highest priority among waiting sources is strictly greater than the current priority. A source with priority 0 never causes a request.
- R5: irqVector names the waiting source with the highest priority. Among sources with equal priority, the lowest index wins.
- R6: An irqAck while irqReq is high saves the current priority on the stack, loads the current priority with the winner's priority, and raises the depth (read at address 3) by one. An irqAck while irqReq is low has no effect.
- R7: A write to address 2 (end of interrupt) restores the most recently saved current priority and lowers the depth by one. With an empty stack it has no effect.
- R8: A write to address 1 sets the current priority from data bits 3:0, unless the value is below the priority of the running handler. Such a write leaves the current priority unchanged and drives prioErr high for the single cycle after the write.
- R9: A lower source raised inside a higher handler requests service right after that handler's end-of-interrupt write, and the higher handler's priority is not restored afterwards.
- R10: Addresses 4+i hold the 4-bit priority of source i (data bits 3:0). They are readable and writable.
- R11: An irqAck in the same cycle as a write to address 1 or 2 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busValid | input | 1 | Bus access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Register address |
| busWData | input | 16 | Write data |
| busRData | output | 16 | Read data, combinational from address |
| irqAck | input | 1 | Processor takes the offered interrupt |
| irqReq | output | 1 | Interrupt request to the processor |
| irqVector | output | 3 | Index of the source to service |
| prioErr | output | 1 | One-cycle pulse for a refused priority write |

## Verification
A wrong waiting bit or priority field shows at once on irqReq and irqVector, in the cycle after the write that caused it. The sweeps compare every waiting pattern against an arithmetic winner, under two priority maps and two current priorities. A corrupted stack entry shows only later: the current priority that comes back after an end-of-interrupt write is wrong. The nesting scenarios therefore read the current priority and depth after every acknowledge and every end-of-interrupt write, and they test whether a lower request wins afterwards.

// File: rtl/swi_sched_pkg.sv
`timescale 1ns/1ps
package swi_sched_pkg;
  localparam int ADDR_SWI       = 0;
  localparam int ADDR_CPR       = 1;
  localparam int ADDR_EOI       = 2;
  localparam int ADDR_DEPTH     = 3;
  localparam int ADDR_PRIO_BASE = 4;

  typedef struct packed {
    logic swiWe;
    logic cprWe;
    logic pop;
    logic push;
    logic prioWe;
  } strobes_t;
endpackage

// File: rtl/swi_sched_ctrl.sv
`timescale 1ns/1ps
module swi_sched_ctrl
  import swi_sched_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  parameter int IDX_W   = 3,
  parameter int SP_W    = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      busValid,
  input  logic                      busWrite,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic [DATA_W-1:0]         busWData,
  input  logic                      irqAck,
  input  logic [NUM_SRC-1:0]        pendQ,
  input  logic [NUM_SRC*PRIO_W-1:0] prioFlat,
  input  logic [PRIO_W-1:0]         curPrio,
  input  logic [PRIO_W-1:0]         runPrio,
  input  logic [SP_W-1:0]           depth,
  output strobes_t                  strb,
  output logic [IDX_W-1:0]          prioIdx,
  output logic [PRIO_W-1:0]         winPrio,
  output logic [IDX_W-1:0]          winIdx,
  output logic                      irqReq,
  output logic                      prioErr
);
  logic wr, cprHit, eoiHit, cprBad;
  logic [ADDR_W-1:0] prioOff;

  // Arbitration: scan from the top index down so that ties keep the lowest index.
  always_comb begin
    winPrio = '0;
    winIdx  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendQ[i] && (prioFlat[i*PRIO_W +: PRIO_W] >= winPrio)) begin
        winPrio = prioFlat[i*PRIO_W +: PRIO_W];
        winIdx  = IDX_W'(i);
      end
    end
  end

  assign irqReq = (winPrio > curPrio);

  assign wr      = busValid && busWrite;
  assign cprHit  = wr && (busAddr == ADDR_W'(ADDR_CPR));
  assign eoiHit  = wr && (busAddr == ADDR_W'(ADDR_EOI));
  assign cprBad  = cprHit && (busWData[PRIO_W-1:0] < runPrio);
  assign prioOff = busAddr - ADDR_W'(ADDR_PRIO_BASE);
  assign prioIdx = prioOff[IDX_W-1:0];

  always_comb begin
    strb.swiWe  = wr && (busAddr == ADDR_W'(ADDR_SWI));
    strb.cprWe  = cprHit && !cprBad;
    strb.pop    = eoiHit && (depth != '0);
    strb.push   = irqAck && irqReq && !cprHit && !eoiHit;
    strb.prioWe = wr && (busAddr >= ADDR_W'(ADDR_PRIO_BASE))
                     && (prioOff < ADDR_W'(NUM_SRC));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prioErr <= 1'b0;
    else       prioErr <= cprBad;
  end
endmodule

// File: rtl/swi_sched_dp.sv
`timescale 1ns/1ps
module swi_sched_dp
  import swi_sched_pkg::*;
#(
  parameter int NUM_SRC    = 8,
  parameter int PRIO_W     = 4,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 16,
  parameter int IDX_W      = 3,
  parameter int SP_W       = 5,
  parameter int LIFO_DEPTH = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobes_t                  strb,
  input  logic [IDX_W-1:0]          prioIdx,
  input  logic [PRIO_W-1:0]         winPrio,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic [DATA_W-1:0]         busWData,
  output logic [DATA_W-1:0]         busRData,
  output logic [NUM_SRC-1:0]        pendQ,
  output logic [NUM_SRC*PRIO_W-1:0] prioFlat,
  output logic [PRIO_W-1:0]         curPrio,
  output logic [PRIO_W-1:0]         runPrio,
  output logic [SP_W-1:0]           depth
);
  localparam int LIDX_W = $clog2(LIFO_DEPTH);
  localparam int ENT_W  = 2 * PRIO_W;

  logic [NUM_SRC-1:0] setMask, clrMask;
  logic [ENT_W-1:0]   lifo [LIFO_DEPTH];
  logic [SP_W-1:0]    depthDec;
  logic [ADDR_W-1:0]  rdOff;

  assign setMask  = strb.swiWe ? busWData[NUM_SRC-1:0] : '0;
  assign clrMask  = strb.swiWe ? busWData[NUM_SRC +: NUM_SRC] : '0;
  assign depthDec = depth - SP_W'(1);

  // Waiting bits: withdraw takes precedence over set.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= (pendQ | setMask) & ~clrMask;
  end

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : gPrio
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          prioFlat[g*PRIO_W +: PRIO_W] <= '0;
        else if (strb.prioWe && (prioIdx == IDX_W'(g)))
          prioFlat[g*PRIO_W +: PRIO_W] <= busWData[PRIO_W-1:0];
      end
    end
  endgenerate

  // Current priority, running handler priority and the nesting stack.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPrio <= '0;
      runPrio <= '0;
      depth   <= '0;
      for (int i = 0; i < LIFO_DEPTH; i++) lifo[i] <= '0;
    end else if (strb.push) begin
      lifo[depth[LIDX_W-1:0]] <= {curPrio, runPrio};
      curPrio <= winPrio;
      runPrio <= winPrio;
      depth   <= depth + SP_W'(1);
    end else if (strb.pop) begin
      {curPrio, runPrio} <= lifo[depthDec[LIDX_W-1:0]];
      depth   <= depthDec;
    end else if (strb.cprWe) begin
      curPrio <= busWData[PRIO_W-1:0];
    end
  end

  assign rdOff = busAddr - ADDR_W'(ADDR_PRIO_BASE);

  always_comb begin
    busRData = '0;
    if (busAddr == ADDR_W'(ADDR_SWI))
      busRData[NUM_SRC +: NUM_SRC] = pendQ;
    else if (busAddr == ADDR_W'(ADDR_CPR))
      busRData[PRIO_W-1:0] = curPrio;
    else if (busAddr == ADDR_W'(ADDR_DEPTH))
      busRData[SP_W-1:0] = depth;
    else if ((busAddr >= ADDR_W'(ADDR_PRIO_BASE)) && (rdOff < ADDR_W'(NUM_SRC)))
      busRData[PRIO_W-1:0] = prioFlat[rdOff[IDX_W-1:0]*PRIO_W +: PRIO_W];
  end
endmodule

// File: rtl/swi_sched.sv
`timescale 1ns/1ps
module swi_sched
  import swi_sched_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busValid,
  input  logic                       busWrite,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [DATA_W-1:0]          busWData,
  output logic [DATA_W-1:0]          busRData,
  input  logic                       irqAck,
  output logic                       irqReq,
  output logic [$clog2(NUM_SRC)-1:0] irqVector,
  output logic                       prioErr
);
  localparam int IDX_W      = $clog2(NUM_SRC);
  localparam int LIFO_DEPTH = 1 << PRIO_W;
  localparam int SP_W       = $clog2(LIFO_DEPTH + 1);

  strobes_t                  strb;
  logic [IDX_W-1:0]          prioIdx, winIdx;
  logic [PRIO_W-1:0]         winPrio, curPrio, runPrio;
  logic [NUM_SRC-1:0]        pendQ;
  logic [NUM_SRC*PRIO_W-1:0] prioFlat;
  logic [SP_W-1:0]           depth;

  swi_sched_ctrl #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .IDX_W(IDX_W), .SP_W(SP_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWData(busWData), .irqAck(irqAck),
    .pendQ(pendQ), .prioFlat(prioFlat), .curPrio(curPrio), .runPrio(runPrio),
    .depth(depth), .strb(strb), .prioIdx(prioIdx), .winPrio(winPrio),
    .winIdx(winIdx), .irqReq(irqReq), .prioErr(prioErr)
  );

  swi_sched_dp #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .IDX_W(IDX_W), .SP_W(SP_W), .LIFO_DEPTH(LIFO_DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .prioIdx(prioIdx), .winPrio(winPrio),
    .busAddr(busAddr), .busWData(busWData), .busRData(busRData),
    .pendQ(pendQ), .prioFlat(prioFlat), .curPrio(curPrio), .runPrio(runPrio),
    .depth(depth)
  );

  assign irqVector = winIdx;
endmodule

// File: rtl/swi_sched_chk.sv
`timescale 1ns/1ps
module swi_sched_chk #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  parameter int IDX_W   = 3,
  parameter int SP_W    = 5
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      busValid,
  input logic                      busWrite,
  input logic [ADDR_W-1:0]         busAddr,
  input logic [DATA_W-1:0]         busWData,
  input logic                      irqAck,
  input logic                      irqReq,
  input logic [IDX_W-1:0]          irqVector,
  input logic                      prioErr,
  input logic [NUM_SRC-1:0]        pendQ,
  input logic [NUM_SRC*PRIO_W-1:0] prioFlat,
  input logic [PRIO_W-1:0]         curPrio,
  input logic [PRIO_W-1:0]         runPrio,
  input logic [SP_W-1:0]           depth
);
  localparam int LIFO_DEPTH = 1 << PRIO_W;

  logic wrCtl, wrCpr, wrEoi, badCpr;
  logic [NUM_SRC-1:0] bothMask;
  assign wrCtl    = busValid && busWrite && (busAddr == ADDR_W'(0));
  assign wrCpr    = busValid && busWrite && (busAddr == ADDR_W'(1));
  assign wrEoi    = busValid && busWrite && (busAddr == ADDR_W'(2));
  assign badCpr   = wrCpr && (busWData[PRIO_W-1:0] < runPrio);
  assign bothMask = busWData[NUM_SRC-1:0] & busWData[NUM_SRC +: NUM_SRC];

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ == '0) |-> !irqReq);

  a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtl && (bothMask != '0)) |=> ((pendQ & $past(bothMask)) == '0));

  a_r4_req_src_waiting: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (pendQ[irqVector] &&
                (prioFlat[irqVector*PRIO_W +: PRIO_W] > curPrio)));

  a_r6_ack_push: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && irqReq && !wrCpr && !wrEoi) |=>
      (depth == $past(depth) + SP_W'(1)) && (curPrio > $past(curPrio)));

  a_r6_depth_bound: assert property (@(posedge clk) disable iff (!rstN)
    depth < SP_W'(LIFO_DEPTH));

  a_r7_eoi_pop: assert property (@(posedge clk) disable iff (!rstN)
    (wrEoi && (depth != '0)) |=> (depth == $past(depth) - SP_W'(1)));

  a_r8_bad_write_refused: assert property (@(posedge clk) disable iff (!rstN)
    badCpr |=> ($stable(curPrio) && prioErr));

  a_r11_ack_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && wrCpr) |=> (depth == $past(depth)));
endmodule

bind swi_sched swi_sched_chk #(
  .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .IDX_W(IDX_W), .SP_W(SP_W)
) i_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busWData(busWData), .irqAck(irqAck), .irqReq(irqReq),
  .irqVector(irqVector), .prioErr(prioErr), .pendQ(pendQ), .prioFlat(prioFlat),
  .curPrio(curPrio), .runPrio(runPrio), .depth(depth)
);

// File: tb/test_swi_sched.sv
`timescale 1ns/100ps
module test_swi_sched;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0, irqAck = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [15:0] busWData = '0;
  logic [15:0] busRData;
  logic        irqReq, prioErr;
  logic [2:0]  irqVector;

  int checks = 0, errors = 0;
  logic [3:0] prioM [8];
  logic [3:0] curM;
  logic [15:0] rd;

  always #2.5 clk = ~clk;

  swi_sched i_swi_sched (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWData(busWData), .busRData(busRData),
    .irqAck(irqAck), .irqReq(irqReq), .irqVector(irqVector), .prioErr(prioErr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [3:0] a, input logic [15:0] d, input logic ack);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWData = d; irqAck = ack;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0; irqAck = 1'b0;
  endtask

  task automatic busRd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRData;
    busValid = 1'b0;
  endtask

  task automatic doAck();
    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
  endtask

  task automatic setPrios(input int mode);
    for (int i = 0; i < 8; i++) begin
      prioM[i] = (mode == 0) ? 4'((i * 7 + 2) % 16) : 4'((i % 4) * 5);
      busWr(4'(4 + i), {12'h0, prioM[i]}, 1'b0);
    end
  endtask

  // Expected winner of pattern p: highest priority, lowest index on ties.
  task automatic sweep(input string tag);
    for (int p = 0; p < 256; p++) begin
      int bestP = 0, bestI = 0;
      busWr(4'd0, {8'(~p), 8'(p)}, 1'b0);
      for (int i = 7; i >= 0; i--)
        if (p[i] && int'(prioM[i]) >= bestP) begin bestP = prioM[i]; bestI = i; end
      check({tag, " R4 req"}, irqReq, (bestP > int'(curM)) ? 1 : 0);
      if (bestP > 0) check({tag, " R5 vector"}, irqVector, bestI);
    end
  endtask

  task automatic stateIs(input string req, input int cur, input int dep);
    busRd(4'd1, rd); check({req, " cur"}, rd, cur);
    busRd(4'd3, rd); check({req, " depth"}, rd, dep);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 irqReq", irqReq, 0);
    check("R1 prioErr", prioErr, 0);
    busRd(4'd0, rd); check("R1 pending", rd, 0);
    stateIs("R1", 0, 0);
    busRd(4'd6, rd); check("R1 prio", rd, 0);

    // R10 priority registers; R4/R5 sweeps under two maps and two current levels
    setPrios(0);
    busRd(4'd5, rd); check("R10 prio1", rd, 9);
    busRd(4'd8, rd); check("R10 prio4", rd, 14);
    curM = 0; sweep("mapA cur0");
    busWr(4'd1, 16'd5, 1'b0); curM = 5;
    busRd(4'd1, rd); check("R8 cpr at depth0", rd, 5);
    sweep("mapA cur5");
    setPrios(1);
    sweep("mapB cur5");
    busWr(4'd1, 16'd0, 1'b0); curM = 0;
    sweep("mapB cur0");

    // R2 readback, R3 withdraw and clear precedence
    busWr(4'd0, 16'hFF00, 1'b0);
    busWr(4'd0, 16'h00A5, 1'b0);
    busRd(4'd0, rd); check("R2 readback", rd, 16'hA500);
    busWr(4'd0, 16'h0501, 1'b0);
    busRd(4'd0, rd); check("R3 partial clr", rd, 16'hA000);
    busWr(4'd0, 16'h0F0F, 1'b0);
    busRd(4'd0, rd); check("R3 clear wins", rd, 16'hA000);
    busWr(4'd0, 16'hFF00, 1'b0);
    check("R4 none waiting", irqReq, 0);

    // Nesting: priority of source i = 2i+1
    for (int i = 0; i < 8; i++) busWr(4'(4 + i), 16'(2 * i + 1), 1'b0);
    doAck();
    stateIs("R6 ack without req", 0, 0);
    busWr(4'd0, 16'h0001, 1'b0);
    check("R4 src0 req", irqReq, 1);
    doAck();
    stateIs("R6 push1", 1, 1);
    check("R4 after ack", irqReq, 0);
    busWr(4'd0, 16'h0008, 1'b0);
    check("R5 src3", irqVector, 3);
    doAck();
    stateIs("R6 push2", 7, 2);
    busWr(4'd0, 16'h0002, 1'b0);
    check("R4 lower inside", irqReq, 0);
    busWr(4'd1, 16'd2, 1'b0);
    check("R8 err pulse", prioErr, 1);
    @(negedge clk);
    check("R8 err single", prioErr, 0);
    stateIs("R8 refused", 7, 2);
    busWr(4'd1, 16'd9, 1'b0);
    check("R8 no err raise", prioErr, 0);
    stateIs("R8 raise ok", 9, 2);
    busWr(4'd0, 16'h0800, 1'b0);
    busWr(4'd0, 16'h0010, 1'b0);
    busWr(4'd2, 16'd0, 1'b1);
    stateIs("R11 ack with eoi", 1, 1);
    check("R9 lower after eoi", irqReq, 1);
    check("R9 vector", irqVector, 4);
    busWr(4'd1, 16'd1, 1'b1);
    stateIs("R11 ack with cpr", 1, 1);
    busWr(4'd0, 16'h1000, 1'b0);
    check("R9 src1 next", irqVector, 1);
    busWr(4'd0, 16'h0300, 1'b0);
    busWr(4'd2, 16'd0, 1'b0);
    stateIs("R7 pop to base", 0, 0);
    busWr(4'd2, 16'd0, 1'b0);
    stateIs("R7 empty eoi", 0, 0);
    check("R7 no req", irqReq, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule